// File: doc/BRIEF.md
# Fractional-Rate Master Time Counter

This block keeps a free-running time count that advances at a fixed nominal rate of 6.144 MHz whatever its input clock frequency is. Each input clock adds a programmable fraction, numerator over denominator, to a remainder accumulator. Whenever the accumulator holds at least one whole step, the count advances by one and the whole step is taken out of the accumulator. Because the remainder is carried forward and never lost, the long-term rate is exact.

Software picks the ratio to match the input clock. The reset ratio is 4/25, which suits a 38.4 MHz input. Other ratios include 8/25 for 19.2 MHz, and 64/125, 256/1125, 384/1625 and 768/1625 for the remaining input clock rates. The count is twice the bus width. It is read as two words, and reading the low word captures the high word so that the two halves form one consistent value.

Top module: `rtc_frac_counter`

## Requirements
- R1: After reset the count and the accumulator are zero, the numerator field is 4, the denominator field is 25, and read data is zero.
- R2: When the numerator is below the denominator, k clocks after the last ratio write the count has advanced by exactly floor(k*num/den).
- R3: On any clock the count either holds or advances by exactly one, and it never decreases or reloads.
- R4: While the numerator is below the denominator, the accumulator stays strictly below the denominator.
- R5: A write to the numerator or denominator register clears the accumulator, and the count holds in that write cycle.
- R6: When the numerator is greater than or equal to the denominator (a zero denominator included), the count advances by one on every clock without a ratio write.
- R7: A write to the numerator register (offset 0x10) or the denominator register (offset 0x14) changes only the low FIELD_W bits. The upper bits read back as zero. An unmapped address reads as zero.
- R8: A read of the low count word (offset 0x00) captures the upper half of the count. A read of the high word (offset 0x04) returns that captured value, even if the count has since carried into its upper half.
- R9: Read data is registered. It appears on rdata in the cycle after rd_en is sampled and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock of varying frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Registered read data |

## Verification
The hardest case to reach is a carry into the upper half of the count that falls between a low-word read and the matching high-word read. A 64-bit count would never get there in a short run. The bench therefore builds the block with a 16-bit bus, so the count is 32 bits wide. It programs a ratio of one or more, so the count gains one per clock, and polls the low word until it sits just below its wrap. It then waits past the carry and reads the high word, which must still show the captured value. Every listed ratio is also swept with a low-word read on each clock over two full denominator periods, and each reading is compared with floor(k*num/den).

// File: rtl/rtc_frac_counter.sv
module rtc_frac_counter #(
  parameter int BUS_W   = 32,
  parameter int FIELD_W = 12,
  parameter int ADDR_W  = 8,
  parameter int NUM_RST = 4,
  parameter int DEN_RST = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata
);
  localparam int CNT_W = 2 * BUS_W;
  localparam logic [ADDR_W-1:0] OFS_LO  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_HI  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_NUM = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_DEN = ADDR_W'(8'h14);

  logic [FIELD_W-1:0] num_q, den_q, acc_q, acc_d;
  logic [CNT_W-1:0]   cnt_q;
  logic [BUS_W-1:0]   hi_q, rmux;

  wire wr_num   = wr_en && (addr == OFS_NUM);
  wire wr_den   = wr_en && (addr == OFS_DEN);
  wire ratio_wr = wr_num || wr_den;

  wire [FIELD_W:0] sum   = {1'b0, acc_q} + {1'b0, num_q};
  wire [FIELD_W:0] rem   = sum - {1'b0, den_q};
  wire             unity = (num_q >= den_q);
  wire             carry = unity || (sum >= {1'b0, den_q});

  always_comb begin
    if (ratio_wr || unity) acc_d = '0;
    else if (carry)        acc_d = rem[FIELD_W-1:0];
    else                   acc_d = sum[FIELD_W-1:0];
  end

  always_comb begin
    case (addr)
      OFS_LO:  rmux = cnt_q[BUS_W-1:0];
      OFS_HI:  rmux = hi_q;
      OFS_NUM: rmux = BUS_W'(num_q);
      OFS_DEN: rmux = BUS_W'(den_q);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= FIELD_W'(NUM_RST);
      den_q <= FIELD_W'(DEN_RST);
      acc_q <= '0;
      cnt_q <= '0;
      hi_q  <= '0;
      rdata <= '0;
    end else begin
      if (wr_num) num_q <= wdata[FIELD_W-1:0];
      if (wr_den) den_q <= wdata[FIELD_W-1:0];
      acc_q <= acc_d;
      if (carry && !ratio_wr) cnt_q <= cnt_q + 1'b1;
      if (rd_en && addr == OFS_LO) hi_q <= cnt_q[CNT_W-1:BUS_W];
      if (rd_en) rdata <= rmux;
    end
  end
endmodule

// File: rtl/rtc_frac_counter_chk.sv
module rtc_frac_counter_chk #(
  parameter int BUS_W   = 32,
  parameter int FIELD_W = 12,
  parameter int ADDR_W  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [FIELD_W-1:0]   num,
  input logic [FIELD_W-1:0]   den,
  input logic [FIELD_W-1:0]   acc,
  input logic [2*BUS_W-1:0]   cnt,
  input logic [BUS_W-1:0]     hi
);
  wire rw = wr_en && (addr == ADDR_W'(8'h10) || addr == ADDR_W'(8'h14));
  wire lo_rd = rd_en && (addr == ADDR_W'(8'h00));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  // R5
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rw |=> (acc == '0 && cnt == $past(cnt)));

  // R4
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (num < den) |-> (acc < den));

  // R6
  unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (num >= den && !rw) |=> (cnt == $past(cnt) + 1'b1));

  // R8
  latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> (hi == $past(cnt[2*BUS_W-1:BUS_W])));
endmodule

bind rtc_frac_counter rtc_frac_counter_chk #(
  .BUS_W(BUS_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .num(num_q), .den(den_q), .acc(acc_q), .cnt(cnt_q), .hi(hi_q)
);

// File: tb/rtc_frac_counter_tb.sv
`timescale 1ns/1ps
module rtc_frac_counter_tb;
  localparam int BW = 16;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = '0;
  logic [BW-1:0] wdata = '0, rdata;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  rtc_frac_counter #(.BUS_W(BW), .FIELD_W(12), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #10 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic re, input logic [7:0] a,
                     input logic [BW-1:0] d, output logic [BW-1:0] q);
    wr_en = we; rd_en = re; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    q = rdata;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic run_ratio(input int n, input int d);
    logic [BW-1:0] q, base;
    int len, ex;
    cyc(1, 0, 8'h14, BW'(d), q);
    cyc(1, 0, 8'h10, BW'(n), q);
    len = 2 * ((d > 10) ? d : 10) + 4;
    base = '0;
    for (int k = 0; k < len; k++) begin
      cyc(0, 1, 8'h00, '0, q);
      if (k == 0) base = q;
      ex = (n >= d) ? k : (k * n) / d;
      if (n >= d) chk("R6 unity step", BW'(q - base), BW'(ex));
      else        chk("R2 fractional count", BW'(q - base), BW'(ex));
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] q, v, lo, h0;
    int guard;
    @(negedge clk); @(negedge clk);
    chk("R1 rdata at reset", rdata, 0);
    rst_n = 1;
    // R1: high word after reset, edge 0
    cyc(0, 1, 8'h04, '0, q);
    chk("R1 high word zero", q, 0);
    // R1 R2: default 4/25 from reset, read at edge j gives floor(j*4/25)
    for (int j = 1; j <= 60; j++) begin
      cyc(0, 1, 8'h00, '0, q);
      chk("R2 default ratio from reset", q, (j * 4) / 25);
    end
    cyc(0, 1, 8'h10, '0, q); chk("R1 numerator reset", q, 4);
    cyc(0, 1, 8'h14, '0, q); chk("R1 denominator reset", q, 25);
    // R9: rdata holds with no read
    cyc(0, 0, 8'h00, '0, v); chk("R9 rdata holds", v, 25);
    // R7
    cyc(0, 1, 8'h08, '0, q); chk("R7 unmapped reads zero", q, 0);
    cyc(1, 0, 8'h10, 16'hF0F5, q);
    cyc(0, 1, 8'h10, '0, q); chk("R7 numerator masked", q, 16'h00F5);
    cyc(1, 0, 8'h14, 16'hABCD, q);
    cyc(0, 1, 8'h14, '0, q); chk("R7 denominator masked", q, 16'h0BCD);
    // R2 sweep over listed ratios
    run_ratio(4, 25);
    run_ratio(8, 25);
    run_ratio(64, 125);
    run_ratio(256, 1125);
    run_ratio(384, 1625);
    run_ratio(768, 1625);
    run_ratio(3, 7);
    // R5: rewriting ratio mid-run restarts the remainder
    run_ratio(24, 25);
    run_ratio(24, 25);
    // R6: unity and above, zero denominator
    run_ratio(7, 7);
    run_ratio(9, 3);
    run_ratio(3, 0);
    // R5: count holds in write cycle (ratio 5/5 gives +1 per clock)
    run_ratio(5, 5);
    cyc(0, 1, 8'h00, '0, v);
    cyc(1, 0, 8'h10, 16'd5, q);
    cyc(0, 1, 8'h00, '0, q);
    chk("R5 count holds on ratio write", BW'(q - v), 1);
    // R8: carry between low and high reads
    guard = 0;
    lo = '0;
    while (guard < 70000) begin
      cyc(0, 1, 8'h00, '0, lo);
      guard++;
      if (lo >= 16'hFFE0) break;
    end
    chk("R8 reached wrap region", (lo >= 16'hFFE0) ? 1 : 0, 1);
    cyc(0, 1, 8'h04, '0, h0);
    for (int i = 0; i < 60; i++) cyc(0, 0, 8'h00, '0, q);
    cyc(0, 1, 8'h04, '0, q);
    chk("R8 high word stays captured", q, h0);
    cyc(0, 1, 8'h00, '0, q);
    chk("R8 low word wrapped", (q < 16'h0100) ? 1 : 0, 1);
    cyc(0, 1, 8'h04, '0, q);
    chk("R8 high word after new capture", q, BW'(h0 + 1));
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule